// File: doc/BRIEF.md
# Module Configuration Integrity Checker

This block checks the integrity of the configuration image stored on a memory module while the image streams past. Bytes arrive one per valid beat, each with its address, after a start pulse. The block reads the memory-type byte and from it decides how the image is protected. Older module generations use a plain 8-bit additive checksum. The newest generation handled here uses a 16-bit CRC, and one flag bit in the first byte selects how much of the image that CRC covers.

Both accumulators run from byte 0, because the type is only known once byte 2 has gone by. When the stored check value arrives, the block compares it and raises a one-cycle done strobe together with a held verdict. It also ends the check early, with a flag of its own and no verdict, in two cases: when it sees a type it does not support, and when the address sequence breaks. A host reads the image from the module, feeds the bytes through this block and reads the verdict once done pulses.

Top module: `cfg_integ_chk`

## Requirements
- R1: Out of reset every result output is low. Each done strobe comes with exactly one of the outcomes pass, fail, unsupported or sequence error.
- R2: When the type byte at address 2 holds 4, 7 or 8, the byte at address 63 is compared with the sum of bytes 0 to 62 taken modulo 256, with no negation. Done rises in the cycle after byte 63 is accepted, with pass high on a match and fail high otherwise.
- R3: When the type byte holds 11, the stored CRC is formed from byte 126 as its low byte and byte 127 as its high byte. It is compared with a CRC-16 that uses polynomial 0x1021 and initial value 0, with no reflection, and takes each byte MSB first. The verdict follows byte 127 by one cycle.
- R4: For type 11, if bit 7 of byte 0 is set the CRC covers bytes 0 to 116 only and bytes 117 to 125 do not affect it. If that bit is clear, the CRC covers bytes 0 to 125.
- R5: Any other type value ends the check in the cycle after byte 2, with done and the unsupported flag high and both pass and fail low.
- R6: After a start, accepted bytes must carry the addresses 0, 1, 2 and so on without a gap. A beat whose address differs from the expected one, including a return to 0 partway through, ends the check with done and the sequence-error flag high and no verdict.
- R7: Done is high for a single cycle. Pass, fail, unsupported and sequence error hold their values until the next start pulse. Bytes that arrive after the check has ended cause no further done and change no result.
- R8: A start pulse clears every result output by the next cycle and begins a fresh check from address 0, even when a check is already under way.
- R9: At most one of pass, fail, unsupported and sequence error is high at any time.
- R10: Cycles with valid low are ignored, so idle cycles may appear between bytes. Valid beats that arrive before any start pulse produce no done and no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a new check and clears the results |
| byte_vld_i | input | 1 | A configuration byte is present this cycle |
| byte_addr_i | input | ADDR_W | Address of the byte within the image |
| byte_data_i | input | 8 | Byte value |
| done_o | output | 1 | One-cycle strobe when a check ends |
| pass_o | output | 1 | Stored check value matched |
| fail_o | output | 1 | Stored check value did not match |
| unsup_o | output | 1 | Type byte names no supported scheme |
| seq_err_o | output | 1 | Address sequence broken, check aborted |

## Verification
On every cycle the assertions check the following: the outcome flags stay mutually exclusive, each done carries exactly one outcome, done never lasts two cycles, results hold between strobes, start clears them, an idle block never strobes and an out-of-order beat aborts in the next cycle. Whether the checksum and CRC values are right can only be shown by the bench's scenarios. The same holds for the choice of scheme from the type byte, the coverage flag excluding bytes 117 to 125 and the byte order of the stored CRC. For these the bench builds images whose sums and CRCs it computes itself, including negated and byte-swapped stored values.

// File: rtl/cic_pkg.sv
package cic_pkg;

   typedef enum logic [1:0] {
      SCH_NONE = 2'd0,
      SCH_SUM  = 2'd1,
      SCH_CRC  = 2'd2
   } cic_scheme_e;

   localparam logic [7:0] MT_GEN1 = 8'd4;
   localparam logic [7:0] MT_GEN2 = 8'd7;
   localparam logic [7:0] MT_GEN3 = 8'd8;
   localparam logic [7:0] MT_GEN4 = 8'd11;

   function automatic cic_scheme_e cic_pick_scheme(input logic [7:0] kind);
      cic_scheme_e s;
      case (kind)
         MT_GEN1, MT_GEN2, MT_GEN3: s = SCH_SUM;
         MT_GEN4:                   s = SCH_CRC;
         default:                   s = SCH_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cic_sum_acc.sv
module cic_sum_acc #(
   parameter int SUM_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [SUM_W-1:0] data_i,
   output logic [SUM_W-1:0] sum_o
);

   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sum_q <= '0;
      else if (clr_i) sum_q <= '0;
      else if (en_i)  sum_q <= sum_q + data_i;
   end

   assign sum_o = sum_q;

endmodule

// File: rtl/cic_crc_acc.sv
module cic_crc_acc #(
   parameter int                CRC_W  = 16,
   parameter int                DATA_W = 8,
   parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
   parameter logic [CRC_W-1:0]  INIT   = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   if (CRC_W < DATA_W) begin : g_bad_width
      $error("cic_crc_acc: CRC_W must be at least DATA_W");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = crc_q;

   // one shift-and-fold stage per data bit, MSB of the byte first
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb         = stage[i][CRC_W-1] ^ data_i[DATA_W-1-i];
      assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    crc_q <= INIT;
      else if (clr_i) crc_q <= INIT;
      else if (en_i)  crc_q <= stage[DATA_W];
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/cic_seq_ctl.sv
module cic_seq_ctl
   import cic_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int CRC_W          = 16,
   parameter int TYPE_ADDR      = 2,
   parameter int SUM_LAST       = 62,
   parameter int CRC_SHORT_LAST = 116,
   parameter int CRC_LONG_LAST  = 125,
   parameter int CRC_LO_ADDR    = 126,
   parameter int COV_FLAG_BIT   = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   input  logic [7:0]        sum_i,
   input  logic [CRC_W-1:0]  crc_i,
   output logic              acc_clr_o,
   output logic              sum_en_o,
   output logic              crc_en_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic              unsup_o,
   output logic              seq_err_o
);

   localparam int SUM_CHK_ADDR = SUM_LAST + 1;
   localparam int CRC_HI_ADDR  = CRC_LO_ADDR + 1;

   localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(TYPE_ADDR);
   localparam logic [ADDR_W-1:0] A_SLAST = ADDR_W'(SUM_LAST);
   localparam logic [ADDR_W-1:0] A_SCHK  = ADDR_W'(SUM_CHK_ADDR);
   localparam logic [ADDR_W-1:0] A_SHORT = ADDR_W'(CRC_SHORT_LAST);
   localparam logic [ADDR_W-1:0] A_LONG  = ADDR_W'(CRC_LONG_LAST);
   localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(CRC_LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(CRC_HI_ADDR);

   if (CRC_W != 16) begin : g_bad_crc_w
      $error("cic_seq_ctl: stored CRC spans two bytes, CRC_W must be 16");
   end
   if ((1 << ADDR_W) <= CRC_HI_ADDR) begin : g_bad_addr_w
      $error("cic_seq_ctl: ADDR_W too narrow for the image");
   end
   if (!(TYPE_ADDR < SUM_LAST && CRC_SHORT_LAST < CRC_LONG_LAST &&
         CRC_LONG_LAST < CRC_LO_ADDR && TYPE_ADDR > 0)) begin : g_bad_layout
      $error("cic_seq_ctl: image layout parameters out of order");
   end
   if (COV_FLAG_BIT > 7) begin : g_bad_flag
      $error("cic_seq_ctl: coverage flag must lie within a byte");
   end

   logic              busy_q;
   logic [ADDR_W-1:0] exp_q;
   logic              short_q;
   cic_scheme_e       scheme_q;
   logic [7:0]        crc_lo_q;
   logic              done_q, pass_q, fail_q, unsup_q, serr_q;

   logic              accept, in_order, hit, bad;
   logic [ADDR_W-1:0] cov_last;
   cic_scheme_e       scheme_now;

   always_comb begin
      accept     = busy_q && vld_i && !start_i;
      in_order   = (addr_i == exp_q);
      hit        = accept && in_order;
      bad        = accept && !in_order;
      cov_last   = short_q ? A_SHORT : A_LONG;
      scheme_now = cic_pick_scheme(data_i);
   end

   assign acc_clr_o = start_i;
   assign sum_en_o  = hit && (addr_i <= A_SLAST);
   assign crc_en_o  = hit && (addr_i <= cov_last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q   <= 1'b0;
         exp_q    <= '0;
         short_q  <= 1'b0;
         scheme_q <= SCH_NONE;
         crc_lo_q <= '0;
         done_q   <= 1'b0;
         pass_q   <= 1'b0;
         fail_q   <= 1'b0;
         unsup_q  <= 1'b0;
         serr_q   <= 1'b0;
      end else if (start_i) begin
         busy_q   <= 1'b1;
         exp_q    <= '0;
         short_q  <= 1'b0;
         scheme_q <= SCH_NONE;
         crc_lo_q <= '0;
         done_q   <= 1'b0;
         pass_q   <= 1'b0;
         fail_q   <= 1'b0;
         unsup_q  <= 1'b0;
         serr_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (bad) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            serr_q <= 1'b1;
         end else if (hit) begin
            exp_q <= exp_q + 1'b1;
            if (addr_i == '0) short_q <= data_i[COV_FLAG_BIT];
            if (addr_i == A_TYPE) begin
               scheme_q <= scheme_now;
               if (scheme_now == SCH_NONE) begin
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  unsup_q <= 1'b1;
               end
            end
            if (scheme_q == SCH_SUM && addr_i == A_SCHK) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               pass_q <= (data_i == sum_i);
               fail_q <= (data_i != sum_i);
            end
            if (scheme_q == SCH_CRC && addr_i == A_LO) crc_lo_q <= data_i;
            if (scheme_q == SCH_CRC && addr_i == A_HI) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               pass_q <= ({data_i, crc_lo_q} == crc_i);
               fail_q <= ({data_i, crc_lo_q} != crc_i);
            end
         end
      end
   end

   assign done_o    = done_q;
   assign pass_o    = pass_q;
   assign fail_o    = fail_q;
   assign unsup_o   = unsup_q;
   assign seq_err_o = serr_q;

   // R9: outcomes are exclusive
   p_outcome_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({pass_q, fail_q, unsup_q, serr_q}));

   // R1: every strobe carries exactly one outcome
   p_done_outcome_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> $onehot({pass_q, fail_q, unsup_q, serr_q}));

   // R7: strobe is one cycle wide
   p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   // R7: results change only together with a strobe or after start
   p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (done_q || $stable({pass_q, fail_q, unsup_q, serr_q})));

   // R8: start clears every result
   p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (!done_q && !pass_q && !fail_q && !unsup_q && !serr_q));

   // R10: no strobe without an active check
   p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && !start_i) |=> !done_q);

   // R6: an out-of-order beat aborts in the next cycle
   p_gap_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && vld_i && !start_i && addr_i != exp_q) |=> (done_q && serr_q));

endmodule

// File: rtl/cfg_integ_chk.sv
module cfg_integ_chk #(
   parameter int              ADDR_W         = 8,
   parameter int              CRC_W          = 16,
   parameter logic [CRC_W-1:0] CRC_POLY      = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT      = '0,
   parameter int              TYPE_ADDR      = 2,
   parameter int              SUM_LAST       = 62,
   parameter int              CRC_SHORT_LAST = 116,
   parameter int              CRC_LONG_LAST  = 125,
   parameter int              CRC_LO_ADDR    = 126,
   parameter int              COV_FLAG_BIT   = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              byte_vld_i,
   input  logic [ADDR_W-1:0] byte_addr_i,
   input  logic [7:0]        byte_data_i,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic              unsup_o,
   output logic              seq_err_o
);

   localparam int BYTE_W = 8;

   logic              acc_clr, sum_en, crc_en;
   logic [BYTE_W-1:0] sum_val;
   logic [CRC_W-1:0]  crc_val;

   cic_sum_acc #(.SUM_W(BYTE_W)) u_sum (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (acc_clr),
      .en_i   (sum_en),
      .data_i (byte_data_i),
      .sum_o  (sum_val)
   );

   cic_crc_acc #(
      .CRC_W  (CRC_W),
      .DATA_W (BYTE_W),
      .POLY   (CRC_POLY),
      .INIT   (CRC_INIT)
   ) u_crc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (acc_clr),
      .en_i   (crc_en),
      .data_i (byte_data_i),
      .crc_o  (crc_val)
   );

   cic_seq_ctl #(
      .ADDR_W         (ADDR_W),
      .CRC_W          (CRC_W),
      .TYPE_ADDR      (TYPE_ADDR),
      .SUM_LAST       (SUM_LAST),
      .CRC_SHORT_LAST (CRC_SHORT_LAST),
      .CRC_LONG_LAST  (CRC_LONG_LAST),
      .CRC_LO_ADDR    (CRC_LO_ADDR),
      .COV_FLAG_BIT   (COV_FLAG_BIT)
   ) u_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .vld_i     (byte_vld_i),
      .addr_i    (byte_addr_i),
      .data_i    (byte_data_i),
      .sum_i     (sum_val),
      .crc_i     (crc_val),
      .acc_clr_o (acc_clr),
      .sum_en_o  (sum_en),
      .crc_en_o  (crc_en),
      .done_o    (done_o),
      .pass_o    (pass_o),
      .fail_o    (fail_o),
      .unsup_o   (unsup_o),
      .seq_err_o (seq_err_o)
   );

endmodule

// File: tb/sim_cfg_integ_chk.sv
`timescale 1ns/1ps
module sim_cfg_integ_chk;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] data = '0;
   logic       done, pass, fail, unsup, serr;

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;
   logic [7:0] img [128];

   always #2.5 clk = ~clk;

   cfg_integ_chk u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .byte_vld_i  (vld),
      .byte_addr_i (addr),
      .byte_data_i (data),
      .done_o      (done),
      .pass_o      (pass),
      .fail_o      (fail),
      .unsup_o     (unsup),
      .seq_err_o   (serr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      chk(act == exp, req, what, act, exp);
   endtask

   function automatic logic [7:0] sum_upto(input int last);
      logic [7:0] s = '0;
      for (int i = 0; i <= last; i++) s = s + img[i];
      return s;
   endfunction

   function automatic logic [15:0] crc_upto(input int last);
      logic [15:0] c = '0;
      for (int i = 0; i <= last; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[15] ^ img[i][b];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
         end
      end
      return c;
   endfunction

   task automatic fill(input int seed, input logic [7:0] b0, input logic [7:0] kind);
      for (int i = 0; i < 128; i++) img[i] = 8'((i * 53 + seed * 17 + 5 + i * i) & 255);
      img[0] = b0;
      img[2] = kind;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // streams addresses first..last (minus skip); counts done strobes and
   // records the address of the beat that produced the last one
   task automatic stream(input int first, input int last, input int skip, input bit gaps,
                         output int n_done, output int done_at);
      int prev = -1;
      n_done = 0; done_at = -1;
      for (int a = first; a <= last; a++) begin
         if (a == skip) continue;
         @(negedge clk);
         if (done) begin n_done++; done_at = prev; end
         vld = 1'b1; addr = 8'(a); data = img[a]; prev = a;
         if (gaps && (a % 7 == 3)) begin
            @(negedge clk);
            if (done) begin n_done++; done_at = prev; end
            vld = 1'b0;
         end
      end
      @(negedge clk);
      if (done) begin n_done++; done_at = prev; end
      vld = 1'b0;
      @(negedge clk);
      if (done) begin n_done++; done_at = prev; end
   endtask

   task automatic t_reset_and_prestart();
      int n, at;
      chk_eq("R1", "done after reset", done, 0);
      chk_eq("R1", "flags after reset", {pass, fail, unsup, serr}, 0);
      fill(1, 8'h20, 8'd4);
      img[63] = sum_upto(62);
      stream(0, 63, -1, 1'b0, n, at);
      chk_eq("R10", "strobes before any start", n, 0);
      chk_eq("R10", "pass before any start", pass, 0);
   endtask

   task automatic t_sum(input int seed, input logic [7:0] kind, input int corrupt,
                        input bit gaps, input string req);
      int n, at;
      fill(seed, 8'hA5, kind);
      case (corrupt)
         0: img[63] = sum_upto(62);
         1: img[63] = ~sum_upto(62);
         default: img[63] = sum_upto(62) + 8'd1;
      endcase
      pulse_start();
      stream(0, 70, -1, gaps, n, at);
      chk_eq("R7", "strobe count", n, 1);
      chk_eq(req, "strobe follows byte", at, 63);
      chk_eq(req, "pass", pass, corrupt == 0 ? 1 : 0);
      chk_eq(req, "fail", fail, corrupt == 0 ? 0 : 1);
      repeat (4) @(negedge clk);
      chk_eq("R7", "verdict held", {pass, fail}, corrupt == 0 ? 2 : 1);
   endtask

   task automatic t_crc(input int seed, input bit short_cov, input int stored_last,
                        input bit swap, input string req);
      int n, at;
      logic [15:0] c;
      int exp_pass;
      fill(seed, short_cov ? 8'h93 : 8'h13, 8'd11);
      c = crc_upto(stored_last);
      img[126] = swap ? c[15:8] : c[7:0];
      img[127] = swap ? c[7:0] : c[15:8];
      exp_pass = (stored_last == (short_cov ? 116 : 125)) &&
                 (!swap || c[15:8] == c[7:0]) ? 1 : 0;
      pulse_start();
      stream(0, 127, -1, 1'b0, n, at);
      chk_eq("R7", "strobe count", n, 1);
      chk_eq("R3", "strobe follows byte", at, 127);
      chk_eq(req, "pass", pass, exp_pass);
      chk_eq(req, "fail", fail, 1 - exp_pass);
   endtask

   task automatic t_unsup(input logic [7:0] kind);
      int n, at;
      fill(7, 8'h00, kind);
      pulse_start();
      stream(0, 63, -1, 1'b0, n, at);
      chk_eq("R5", "strobe follows type byte", at, 2);
      chk_eq("R7", "later bytes give no strobe", n, 1);
      chk_eq("R5", "unsupported flag", unsup, 1);
      chk_eq("R5", "no verdict", {pass, fail}, 0);
   endtask

   task automatic t_gap();
      int n, at;
      fill(9, 8'h00, 8'd4);
      pulse_start();
      stream(0, 63, 10, 1'b0, n, at);
      chk_eq("R6", "gap aborts at beat", at, 11);
      chk_eq("R6", "strobe count", n, 1);
      chk_eq("R6", "sequence flag", serr, 1);
      chk_eq("R6", "no verdict", {pass, fail, unsup}, 0);
   endtask

   task automatic t_restart();
      int n, at;
      fill(11, 8'h00, 8'd8);
      pulse_start();
      stream(0, 20, -1, 1'b0, n, at);
      chk_eq("R6", "no strobe mid image", n, 0);
      stream(0, 5, -1, 1'b0, n, at);
      chk_eq("R6", "restart aborts at address 0", at, 0);
      chk_eq("R6", "sequence flag on restart", serr, 1);
      pulse_start();
      chk_eq("R8", "start clears sequence flag", serr, 0);
   endtask

   task automatic t_start_mid();
      int n, at;
      fill(13, 8'h40, 8'd7);
      img[63] = sum_upto(62);
      pulse_start();
      stream(0, 30, -1, 1'b0, n, at);
      chk_eq("R8", "no strobe before restart", n, 0);
      pulse_start();
      stream(0, 63, -1, 1'b0, n, at);
      chk_eq("R8", "fresh check strobes once", n, 1);
      chk_eq("R8", "fresh check passes", pass, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_prestart();
      t_sum(2, 8'd4, 0, 1'b1, "R2");
      t_sum(3, 8'd8, 1, 1'b0, "R2");
      t_sum(4, 8'd7, 2, 1'b0, "R2");
      t_sum(5, 8'd7, 0, 1'b0, "R2");
      t_crc(6, 1'b0, 125, 1'b0, "R3");
      t_crc(8, 1'b0, 125, 1'b1, "R3");
      t_crc(10, 1'b1, 116, 1'b0, "R4");
      t_crc(12, 1'b1, 125, 1'b0, "R4");
      t_crc(14, 1'b0, 116, 1'b0, "R4");
      t_unsup(8'd9);
      t_unsup(8'd0);
      t_gap();
      t_restart();
      t_start_mid();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule